// File: doc/BRIEF.md
# Masked Raster-Op Word Merger

This unit produces one destination word of a rectangular bit-block copy. Each request carries the word now held in the destination, a source word already shifted into line with it, a two-bit logic operation and a flag that inverts the source. It also carries the leftmost and rightmost bit positions of the span and a two-bit code that says where the word sits in a scan line. From these the unit builds a write mask and combines source with destination under the chosen operation. It returns a word in which only the masked bits can differ from the old destination.

A sequencer outside the block walks each scan line and issues one request per destination word. It marks the word as the left edge, an interior word, the right edge, or a span that fits in a single word, and writes the returned word back to memory. The unit does no memory access, address arithmetic or source shifting. Results come out of a single output register with a valid/ready handshake on both sides.

Top module: `rop_word_merge`

## Requirements
- R1: While reset is held and in the first cycle after it, `res_valid` is 0 and `req_ready` is 1.
- R2: The operation code `op` selects the combination of source and destination: 0 writes the source, 1 writes source AND destination, 2 writes source OR destination, 3 writes source XOR destination.
- R3: When `src_inv` is 1, the source word is inverted before the operation in R2 is applied.
- R4: Bit positions count from the most significant bit, so position i is vector bit 31−i of a 32-bit word. With `place` = 1 (left edge), the mask covers positions `lbit` through 31 and `rbit` has no effect.
- R5: With `place` = 2 (right edge), the mask covers positions 0 through `rbit` and `lbit` has no effect.
- R6: With `place` = 3 (single word), the mask covers only the positions that both the R4 and R5 masks cover. With `place` = 0 (interior), every bit is masked. In all cases, bits outside the mask keep the value of `dst_word`.
- R7: A request accepted on a clock edge (`req_valid` and `req_ready` both 1) shows up as `res_valid` = 1 with its result in the cycle right after that edge. When the output is free every cycle, one request can be accepted on every edge.
- R8: While `res_valid` is 1 and `res_ready` is 0, `res_word` and `res_valid` hold their values and `req_ready` is 0. Results are delivered in acceptance order, and none is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| dst_word | input | 32 | Current destination word |
| src_word | input | 32 | Aligned source word |
| op | input | 2 | 0 replace, 1 AND, 2 OR, 3 XOR |
| src_inv | input | 1 | Invert source before the operation |
| lbit | input | 5 | Leftmost span position, MSB-first |
| rbit | input | 5 | Rightmost span position, MSB-first |
| place | input | 2 | 0 interior, 1 left edge, 2 right edge, 3 single word |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_word | output | 32 | Merged destination word |

## Verification
The hardest case to reach is a result that sits stalled in the output register while a new request waits at the input. In that state the result must not change and nothing may be overwritten. The bench drives `res_ready` from a pseudo-random sequence during the later part of the run. Requests then meet a full register on many edges, including ones where the stall ends on the same edge that a new request is taken. Before that, a phase with the output always ready issues requests back to back. This phase covers the mask extremes (position 0, position 31, and a single-bit span with left equal to right) and every operation with and without inversion.

// File: rtl/rop_word_merge.sv
module rop_word_merge #(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [W-1:0]         dst_word,
  input  logic [W-1:0]         src_word,
  input  logic [1:0]           op,
  input  logic                 src_inv,
  input  logic [$clog2(W)-1:0] lbit,
  input  logic [$clog2(W)-1:0] rbit,
  input  logic [1:0]           place,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [W-1:0]         res_word
);
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic [W-1:0] src_eff, op_out, left_m, right_m, mask, merged;
  logic         take;

  assign src_eff = src_inv ? ~src_word : src_word;

  always_comb begin
    case (op)
      2'd0: op_out = src_eff;
      2'd1: op_out = src_eff & dst_word;
      2'd2: op_out = src_eff | dst_word;
      default: op_out = src_eff ^ dst_word;
    endcase
  end

  assign left_m  = (lbit == '0) ? ONES : ~(ONES << (W - int'(lbit)));
  assign right_m = ONES << (W - 1 - int'(rbit));

  always_comb begin
    case (place)
      2'd0: mask = ONES;
      2'd1: mask = left_m;
      2'd2: mask = right_m;
      default: mask = left_m & right_m;
    endcase
  end

  assign merged    = (op_out & mask) | (dst_word & ~mask);
  assign req_ready = !res_valid || res_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_word  <= '0;
    end else if (take) begin
      res_valid <= 1'b1;
      res_word  <= merged;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

module rop_word_merge_chk #(
  parameter int W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [W-1:0]         dst_word,
  input logic [W-1:0]         src_word,
  input logic [1:0]           op,
  input logic                 src_inv,
  input logic [1:0]           place,
  input logic                 res_valid,
  input logic                 res_ready,
  input logic [W-1:0]         res_word
);
  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> res_valid); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_word)); // R8
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !req_ready); // R8
  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready && !req_valid |=> !res_valid); // R8
  AST_FULL_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && place == 2'd0 && op == 2'd0 && !src_inv
    |=> res_word == $past(src_word)); // R2
  AST_OR_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && op == 2'd2 && !src_inv && src_word == '0
    |=> res_word == $past(dst_word)); // R6
  AST_INV_XOR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && place == 2'd0 && op == 2'd3 && src_inv && src_word == '0
    |=> res_word == ~$past(dst_word)); // R3
endmodule

bind rop_word_merge rop_word_merge_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .dst_word(dst_word), .src_word(src_word), .op(op), .src_inv(src_inv),
  .place(place), .res_valid(res_valid), .res_ready(res_ready), .res_word(res_word)
);

// File: tb/sim_rop_word_merge.sv
`timescale 1ns/1ps
module sim_rop_word_merge;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, src_inv = 0, res_valid, res_ready = 1;
  logic [31:0] dst_word = 0, src_word = 0, res_word;
  logic [1:0] op = 0, place = 0;
  logic [4:0] lbit = 0, rbit = 0;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic bp_mode = 0, done = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  rop_word_merge u0 (.*);

  function automatic logic [31:0] model(logic [31:0] d, logic [31:0] s, logic [1:0] o,
                                        logic inv, logic [4:0] l, logic [4:0] r, logic [1:0] pl);
    logic [31:0] se, m, res;
    se = inv ? ~s : s;
    case (o)
      2'd0: res = se;
      2'd1: res = se & d;
      2'd2: res = se | d;
      default: res = se ^ d;
    endcase
    for (int i = 0; i < 32; i++) begin
      logic inl, inr;
      inl = (i >= int'(l));
      inr = (i <= int'(r));
      case (pl)
        2'd0: m[31-i] = 1'b1;
        2'd1: m[31-i] = inl;
        2'd2: m[31-i] = inr;
        default: m[31-i] = inl && inr;
      endcase
    end
    return (res & m) | (d & ~m);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(string req, logic [31:0] d, logic [31:0] s, logic [1:0] o,
                      logic inv, logic [4:0] l, logic [4:0] r, logic [1:0] pl);
    req_valid = 1; dst_word = d; src_word = s; op = o; src_inv = inv;
    lbit = l; rbit = r; place = pl;
    while (!req_ready) begin @(negedge clk); #1; end
    exp_q.push_back(model(d, s, o, inv, l, r, pl));
    tag_q.push_back(req);
    @(posedge clk);
    @(negedge clk); #1;
    req_valid = 0;
    chk("R7 valid one cycle after accept", {31'b0, res_valid}, 32'd1);
  endtask

  // monitor / scoreboard
  logic stall_prev = 0;
  logic [31:0] stall_word = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        chk("R8 stalled valid held", {31'b0, res_valid}, 32'd1);
        chk("R8 stalled word held", res_word, stall_word);
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      res_ready = bp_mode ? lfsr[0] : 1'b1;
      if (res_valid && res_ready) begin
        if (exp_q.size() == 0) chk("R8 unexpected result", res_word, 32'hxxxxxxxx);
        else chk(tag_q.pop_front(), res_word, exp_q.pop_front());
      end
      stall_prev = res_valid && !res_ready;
      stall_word = res_word;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    chk("R1 valid low in reset", {31'b0, res_valid}, 32'd0);
    chk("R1 ready high in reset", {31'b0, req_ready}, 32'd1);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 valid low after reset", {31'b0, res_valid}, 32'd0);

    a = 32'hF0F0_3C3C; b = 32'h0FF0_A5A5;
    for (int o = 0; o < 4; o++) send("R2 op interior", b, a, 2'(o), 0, 0, 31, 0);
    for (int o = 0; o < 4; o++) send("R3 inverted source", b, a, 2'(o), 1, 7, 9, 0);
    send("R4 left edge L0", 32'h0, 32'hFFFF_FFFF, 0, 0, 0, 4, 1);
    send("R4 left edge L1", 32'h0, 32'hFFFF_FFFF, 0, 0, 1, 4, 1);
    send("R4 left edge L17", 32'h1234_5678, 32'hFFFF_FFFF, 3, 0, 17, 2, 1);
    send("R4 left edge L31", 32'hFFFF_FFFF, 32'h0, 0, 0, 31, 0, 1);
    send("R5 right edge R0", 32'h0, 32'hFFFF_FFFF, 0, 0, 9, 0, 2);
    send("R5 right edge R15", 32'hAAAA_AAAA, 32'hFFFF_FFFF, 2, 0, 30, 15, 2);
    send("R5 right edge R31", 32'h0, 32'hFFFF_FFFF, 0, 0, 3, 31, 2);
    send("R6 single span 3..10", 32'h5555_5555, 32'hFFFF_FFFF, 3, 0, 3, 10, 3);
    send("R6 single span 0..31", 32'h5555_5555, 32'h0F0F_0F0F, 0, 0, 0, 31, 3);
    send("R6 single bit 5", 32'h0, 32'hFFFF_FFFF, 0, 0, 5, 5, 3);
    send("R6 OR zero keeps dst", 32'hDEAD_BEEF, 32'h0, 2, 0, 2, 20, 3);

    bp_mode = 1;
    for (int k = 0; k < 120; k++) begin
      a = $urandom; b = $urandom;
      send("R8 random with backpressure", a, b, 2'($urandom), 1'($urandom),
           5'($urandom), 5'($urandom), 2'($urandom));
    end
    bp_mode = 0;
    repeat (6) @(negedge clk);
    chk("R8 all results delivered", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule